// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block gathers a fixed set of interrupt request lines and keeps four kinds of state for each line: whether it is enabled, pending or active, plus a priority byte and a trigger setting. A small register bus lets software set and read that state. Enable, pending and active bits each have a set word and a clear word, so software can change single bits without a read-modify-write. Priority and target bytes can be written one byte at a time. Each request input is latched into the pending state, either on a rising edge or by following the input level. The trigger setting of the line decides which.

A combinational arbiter watches every line that is pending, enabled and not active. It always presents the best such line to one CPU-interface port: the line with the smallest priority value wins, and on a tie the lower line number wins. The port shows the line number, its priority and a valid flag. The CPU side sends an activate strobe when it takes a line and a deactivate strobe when it has finished with it. The lowest sixteen line numbers are kept for software-raised interrupts. Their request inputs are ignored, and their trigger setting is fixed.

Top module: `irq_distributor`

## Requirements
- R1: After reset, every enable, pending, active, priority and target value is zero and the global enable is off. Whenever no line is being presented, irq_valid is 0, irq_id is 0 and irq_prio is 0xFF.
- R2: Bit 0 of the word at 0x000 is the global enable. While it is 0, irq_valid stays 0. Reading the word returns the bit in bit 0.
- R3: The word at 0x004 is read-only. Its bits [4:0] read NLINES/32-1, and all other bits read 0.
- R4: Writing a 1 to bit line%32 of word 0x100+4*(line/32) enables that line. Writing a 1 to the same bit of word 0x180+4*(line/32) disables it. Zero bits leave lines unchanged. Both words read back the current enable bits.
- R5: Each line has a priority byte at 0x400+line and a target byte at 0x800+line. Byte strobe k writes data bits [8k+7:8k] into the byte at word address + k. Bytes whose strobe is low keep their value.
- R6: Each line has a 2-bit trigger field at bits [2*(line%16)+1 : 2*(line%16)] of word 0xC00+4*(line/16). Upper bit 1 selects edge mode and 0 selects level mode. Lines 0 to 15 always read 2'b10, ignore writes, and ignore their request inputs.
- R7: For an edge-mode line, a 0-to-1 change on its input sets pending. An input that is held high does not set pending again after pending has been cleared.
- R8: For a level-mode line that is not active, pending equals the request input (or 1 in a cycle with a pending-set write).
- R9: The presented line is the pending, enabled, non-active line with the smallest priority byte, with ties going to the lowest line number. irq_prio carries that line's priority byte.
- R10: An activate strobe with an ID sets that line active and clears its pending bit.
- R11: A deactivate strobe with an ID clears that line's active bit. The deactivate strobe wins over an activate of the same line in the same cycle.
- R12: Pending uses set and clear words at 0x200 and 0x280, and active uses set and clear words at 0x300 and 0x380, with the same bit layout as R4. Both words of a pair read back the current bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Request inputs, one per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_be | input | 4 | Byte strobes for priority and target writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_act | input | 1 | Activate strobe |
| cpu_act_id | input | IDW | Line taken by the CPU |
| cpu_deact | input | 1 | Deactivate strobe |
| cpu_deact_id | input | IDW | Line finished by the CPU |
| irq_valid | output | 1 | A line is being presented |
| irq_id | output | IDW | Presented line number |
| irq_prio | output | 8 | Priority byte of the presented line |

## Verification
The bench targets corner cases where a plausible mistake would still look mostly right.

- Two lines with equal priority: a design that broke ties the wrong way would present line 40 instead of line 20.
- An edge line whose input stays high after software clears its pending bit: a design that detected level instead of rising edge would set pending again at once.
- A level line after it is deactivated: pending must come back one cycle later while the input is still high. A design that missed this, or cleared pending without an activate, would show irq_valid low at that point.
- Clear words written with zero bits, software-line trigger writes, partial byte strobes, and an active-set word that hides a pending line: each would expose a decoder that touched the wrong bits.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NLINES = 64,
  localparam int IDW = $clog2(NLINES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cpu_act,
  input  logic [IDW-1:0]    cpu_act_id,
  input  logic              cpu_deact,
  input  logic [IDW-1:0]    cpu_deact_id,
  output logic              irq_valid,
  output logic [IDW-1:0]    irq_id,
  output logic [7:0]        irq_prio
);
  localparam int NW = NLINES / 32;

  logic              ctrl_q;
  logic [NLINES-1:0] en_q, pend_q, act_q, in_q;
  logic [NLINES-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
  logic [NLINES-1:0] pend_nx, act_nx;
  logic [7:0]        prio_q [NLINES];
  logic [7:0]        tgt_q  [NLINES];
  logic [1:0]        cfg_q  [NLINES];

  wire       s_ctrl   = bus_addr == 12'h000;
  wire       s_type   = bus_addr == 12'h004;
  wire       in_banks = bus_addr[11:10] == 2'b00 && bus_addr[9:8] != 2'b00;
  wire [2:0] bank     = bus_addr[9:7];
  wire       s_prio   = bus_addr[11:10] == 2'b01;
  wire       s_tgt    = bus_addr[11:10] == 2'b10;
  wire       s_cfg    = bus_addr[11:8] == 4'hC;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      logic hit, ahit, dhit, hw, edge_m;
      hit  = bus_we && in_banks && bus_addr[6:2] == 5'(i / 32) && bus_wdata[i % 32];
      en_set[i] = hit && bank == 3'd2;
      en_clr[i] = hit && bank == 3'd3;
      pd_set[i] = hit && bank == 3'd4;
      pd_clr[i] = hit && bank == 3'd5;
      ac_set[i] = hit && bank == 3'd6;
      ac_clr[i] = hit && bank == 3'd7;
      ahit   = cpu_act && cpu_act_id == IDW'(i);
      dhit   = cpu_deact && cpu_deact_id == IDW'(i);
      hw     = (i >= 16) ? irq_in[i] : 1'b0;
      edge_m = cfg_q[i][1];
      act_nx[i] = (act_q[i] | ac_set[i] | ahit) & ~ac_clr[i] & ~dhit;
      if (ahit)
        pend_nx[i] = 1'b0;
      else if (!edge_m && !act_q[i])
        pend_nx[i] = hw | pd_set[i];
      else
        pend_nx[i] = (pend_q[i] | pd_set[i] | (edge_m & hw & ~in_q[i])) & ~pd_clr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      in_q   <= '0;
      for (int i = 0; i < NLINES; i++) begin
        prio_q[i] <= 8'h00;
        tgt_q[i]  <= 8'h00;
        cfg_q[i]  <= (i < 16) ? 2'b10 : 2'b00;
      end
    end else begin
      in_q   <= irq_in;
      if (bus_we && s_ctrl) ctrl_q <= bus_wdata[0];
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= pend_nx;
      act_q  <= act_nx;
      for (int i = 0; i < NLINES; i++) begin
        if (bus_we && s_prio && bus_addr[9:2] == 8'(i / 4) && bus_be[i % 4])
          prio_q[i] <= bus_wdata[8*(i%4) +: 8];
        if (bus_we && s_tgt && bus_addr[9:2] == 8'(i / 4) && bus_be[i % 4])
          tgt_q[i] <= bus_wdata[8*(i%4) +: 8];
        if (i >= 16 && bus_we && s_cfg && bus_addr[7:2] == 6'(i / 16))
          cfg_q[i] <= bus_wdata[2*(i%16) +: 2];
      end
    end
  end

  always_comb begin
    logic           found;
    logic [7:0]     best_p;
    logic [IDW-1:0] best_id;
    found   = 1'b0;
    best_p  = 8'hFF;
    best_id = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (pend_q[i] && en_q[i] && !act_q[i] && (!found || prio_q[i] < best_p)) begin
        found   = 1'b1;
        best_p  = prio_q[i];
        best_id = IDW'(i);
      end
    end
    irq_valid = ctrl_q && found;
    irq_id    = irq_valid ? best_id : '0;
    irq_prio  = irq_valid ? best_p : 8'hFF;
  end

  always_comb begin
    bus_rdata = '0;
    if (s_ctrl)
      bus_rdata[0] = ctrl_q;
    else if (s_type)
      bus_rdata = 32'(NW - 1);
    else if (in_banks) begin
      for (int i = 0; i < NLINES; i++)
        if (bus_addr[6:2] == 5'(i / 32))
          case (bank)
            3'd2, 3'd3: bus_rdata[i % 32] = en_q[i];
            3'd4, 3'd5: bus_rdata[i % 32] = pend_q[i];
            default:    bus_rdata[i % 32] = act_q[i];
          endcase
    end else if (s_prio || s_tgt) begin
      for (int i = 0; i < NLINES; i++)
        if (bus_addr[9:2] == 8'(i / 4))
          bus_rdata[8*(i%4) +: 8] = s_prio ? prio_q[i] : tgt_q[i];
    end else if (s_cfg) begin
      for (int i = 0; i < NLINES; i++)
        if (bus_addr[7:2] == 6'(i / 16))
          bus_rdata[2*(i%16) +: 2] = cfg_q[i];
    end
  end

  AST_CTRL_OFF_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && s_ctrl && !bus_wdata[0]) |=> !irq_valid); // R2
  AST_TYPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    s_type |-> bus_rdata == 32'(NW - 1)); // R3
  AST_EN_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_banks && bank == 3'd3 && bus_addr[6:2] == 5'd0 && &bus_wdata) |=> en_q[31:0] == 32'h0); // R4
  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> en_q[irq_id] && pend_q[irq_id] && !act_q[irq_id]); // R9
  AST_ACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_act && !cpu_deact && !bus_we) |=> act_q[$past(cpu_act_id)] && !pend_q[$past(cpu_act_id)]); // R10
  AST_DEACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_deact |=> !act_q[$past(cpu_deact_id)]); // R11
endmodule

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
  localparam int N = 64;
  localparam int IW = $clog2(N);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  irq = '0;
  logic          bus_we = 0;
  logic [11:0]   bus_addr = '0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cpu_act = 0, cpu_deact = 0;
  logic [IW-1:0] cpu_act_id = '0, cpu_deact_id = '0;
  logic          irq_valid;
  logic [IW-1:0] irq_id;
  logic [7:0]    irq_prio;

  irq_distributor #(.NLINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_act(cpu_act), .cpu_act_id(cpu_act_id), .cpu_deact(cpu_deact),
    .cpu_deact_id(cpu_deact_id), .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio));

  always #10 clk = ~clk;

  int    vecs = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  bit m_ctrl;
  bit m_en[N], m_pd[N], m_ac[N], m_inq[N];
  int m_pr[N], m_tg[N], m_cf[N];

  task automatic model_reset();
    m_ctrl = 0;
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_inq[i] = 0;
      m_pr[i] = 0; m_tg[i] = 0; m_cf[i] = (i < 16) ? 2 : 0;
    end
  endtask

  task automatic model_step();
    int a = int'(bus_addr);
    for (int i = 0; i < N; i++) begin
      bit wb = bus_we && a >= 'h100 && a < 'h400 && ((a >> 2) & 31) == i / 32 && bus_wdata[i % 32];
      int bk = a >> 7;
      bit ah = cpu_act && int'(cpu_act_id) == i;
      bit dh = cpu_deact && int'(cpu_deact_id) == i;
      bit hw = (i >= 16) && irq[i];
      bit psw = wb && bk == 4;
      bit old_ac = m_ac[i];
      if (wb && bk == 2) m_en[i] = 1;
      if (wb && bk == 3) m_en[i] = 0;
      if (ah) m_pd[i] = 0;
      else if (m_cf[i] < 2 && !old_ac) m_pd[i] = hw || psw;
      else begin
        if (psw || (m_cf[i] >= 2 && hw && !m_inq[i])) m_pd[i] = 1;
        if (wb && bk == 5) m_pd[i] = 0;
      end
      if (wb && bk == 6) m_ac[i] = 1;
      if (ah) m_ac[i] = 1;
      if (wb && bk == 7) m_ac[i] = 0;
      if (dh) m_ac[i] = 0;
      m_inq[i] = irq[i];
      if (bus_we && a >= 'h400 && a < 'h800 && (a - 'h400) / 4 == i / 4 && bus_be[i % 4])
        m_pr[i] = int'(bus_wdata[8*(i%4) +: 8]);
      if (bus_we && a >= 'h800 && a < 'hC00 && (a - 'h800) / 4 == i / 4 && bus_be[i % 4])
        m_tg[i] = int'(bus_wdata[8*(i%4) +: 8]);
      if (bus_we && i >= 16 && (a >> 8) == 12 && ((a >> 2) & 63) == i / 16)
        m_cf[i] = int'(bus_wdata[2*(i%16) +: 2]);
    end
    if (bus_we && a == 0) m_ctrl = bus_wdata[0];
  endtask

  function automatic logic [31:0] m_rd(int a);
    logic [31:0] r = 0;
    if (a == 0) r[0] = m_ctrl;
    else if (a == 4) r = N / 32 - 1;
    else if (a >= 'h100 && a < 'h400) begin
      int w = (a >> 2) & 31;
      int bk = a >> 7;
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < N)
          r[b] = (bk < 4) ? m_en[w*32+b] : (bk < 6) ? m_pd[w*32+b] : m_ac[w*32+b];
    end else if (a >= 'h400 && a < 'hC00) begin
      int base = ((a & 'h3FF) / 4) * 4;
      for (int b = 0; b < 4; b++)
        if (base + b < N) r[8*b +: 8] = 8'((a < 'h800) ? m_pr[base+b] : m_tg[base+b]);
    end else if (a >= 'hC00 && a < 'hD00) begin
      int w = (a - 'hC00) >> 2;
      for (int f = 0; f < 16; f++)
        if (w * 16 + f < N) r[2*f +: 2] = 2'(m_cf[w*16+f]);
    end
    return r;
  endfunction

  task automatic m_arb(output bit v, output int id, output int p);
    v = 0; id = 0; p = 255;
    for (int pr = 0; pr < 256 && !v; pr++)
      for (int i = 0; i < N && !v; i++)
        if (m_pd[i] && m_en[i] && !m_ac[i] && m_pr[i] == pr) begin
          v = 1; id = i; p = pr;
        end
    if (!m_ctrl) begin v = 0; id = 0; p = 255; end
  endtask

  task automatic compare();
    bit v; int id, p;
    logic [31:0] er;
    m_arb(v, id, p);
    er = m_rd(int'(bus_addr));
    vecs++;
    if (irq_valid !== v || int'(irq_id) !== id || int'(irq_prio) !== p) begin
      fails++;
      $display("FAIL %s port: got v=%0b id=%0d p=%0h exp v=%0b id=%0d p=%0h",
               cur_req, irq_valid, irq_id, irq_prio, v, id, p);
    end
    vecs++;
    if (bus_rdata !== er) begin
      fails++;
      $display("FAIL %s rdata @%h: got %h exp %h", cur_req, bus_addr, bus_rdata, er);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    cyc();
    bus_we = 0; bus_wdata = '0; bus_be = 4'hF;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp);
  endtask

  task automatic act(logic [IW-1:0] id);
    cpu_act = 1; cpu_act_id = id; cyc(); cpu_act = 0;
  endtask

  task automatic deact(logic [IW-1:0] id);
    cpu_deact = 1; cpu_deact_id = id; cyc(); cpu_deact = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cyc();
    cur_req = "R1";
    chk("R1", {31'b0, irq_valid}, 0);
    chk("R1", 32'(irq_prio), 32'hFF);
    rd_chk("R1", 12'h100, 0);
    rd_chk("R3", 12'h004, 32'h1);
    rd_chk("R6", 12'hC00, 32'hAAAAAAAA);
    cur_req = "R2";
    wr(12'h000, 1);
    rd_chk("R2", 12'h000, 1);
    cur_req = "R4";
    wr(12'h100, 32'h1 << 20);
    wr(12'h104, 32'h1 << 8);
    cur_req = "R5";
    wr(12'h414, 32'h80, 4'b0001);
    wr(12'h428, 32'h40, 4'b0001);
    cur_req = "R6";
    wr(12'hC08, 32'h1 << 17);
    cur_req = "R8";
    irq[20] = 1; cyc();
    chk("R8", {irq_valid, 24'(irq_id), irq_prio}, {1'b1, 24'd20, 8'h80});
    cur_req = "R7";
    irq[40] = 1; cyc(); irq[40] = 0; cyc();
    chk("R7", {irq_valid, 24'(irq_id), irq_prio}, {1'b1, 24'd40, 8'h40});
    cur_req = "R9";
    wr(12'h414, 32'h40, 4'b0001);
    chk("R9", 32'(irq_id), 20);
    cur_req = "R10";
    act(20);
    chk("R10", 32'(irq_id), 40);
    rd_chk("R10", 12'h200, 0);
    rd_chk("R12", 12'h300, 32'h1 << 20);
    rd_chk("R12", 12'h380, 32'h1 << 20);
    rd_chk("R12", 12'h204, 32'h100);
    rd_chk("R12", 12'h284, 32'h100);
    act(40);
    chk("R10", {31'b0, irq_valid}, 0);
    cur_req = "R11";
    deact(20);
    chk("R11", {31'b0, irq_valid}, 0);
    cyc();
    chk("R11", {irq_valid, 24'(irq_id), irq_prio}, {1'b1, 24'd20, 8'h40});
    deact(40);
    cur_req = "R7";
    irq[40] = 1; cyc();
    rd_chk("R7", 12'h204, 32'h100);
    wr(12'h284, 32'h100);
    cyc(); cyc();
    rd_chk("R7", 12'h204, 0);
    cur_req = "R8";
    irq[20] = 0; cyc();
    chk("R8", {31'b0, irq_valid}, 0);
    irq[20] = 1; cyc();
    cur_req = "R4";
    wr(12'h180, ~(32'h1 << 20));
    rd_chk("R4", 12'h100, 32'h1 << 20);
    chk("R4", 32'(irq_id), 20);
    wr(12'h180, 32'h1 << 20);
    chk("R4", {31'b0, irq_valid}, 0);
    rd_chk("R4", 12'h100, 0);
    rd_chk("R4", 12'h184, 32'h100);
    cur_req = "R6";
    wr(12'hC00, 0);
    rd_chk("R6", 12'hC00, 32'hAAAAAAAA);
    rd_chk("R6", 12'hC08, 32'h1 << 17);
    wr(12'h100, 32'h8);
    irq[3] = 1; cyc(); cyc();
    chk("R6", {31'b0, irq_valid}, 0);
    cur_req = "R12";
    wr(12'h200, 32'h8);
    chk("R12", {irq_valid, 24'(irq_id), irq_prio}, {1'b1, 24'd3, 8'h00});
    irq[3] = 0;
    cur_req = "R5";
    wr(12'h814, 32'h11223344, 4'b0101);
    rd_chk("R5", 12'h814, 32'h00220044);
    rd_chk("R5", 12'h414, 32'h00000040);
    cur_req = "R12";
    wr(12'h300, 32'h8);
    chk("R12", {31'b0, irq_valid}, 0);
    rd_chk("R12", 12'h380, 32'h8);
    wr(12'h380, 32'h8);
    chk("R12", 32'(irq_id), 3);
    cur_req = "R2";
    wr(12'h000, 0);
    chk("R2", {31'b0, irq_valid}, 0);
    chk("R1", {24'(irq_id), irq_prio}, {24'd0, 8'hFF});
    rd_chk("R2", 12'h000, 0);
    repeat (4) cyc();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule